// File: doc/BRIEF.md
# Indirect Memory Access Port

This block gives a host a narrow window into a word-addressed internal memory. The host never addresses the memory directly. It loads a word pointer into one register and then moves data through a second register. A write to the data register stores the host word at the pointed-to location. A read of the data register fetches the word at that location from a synchronous single-port RAM, and the bus waits through the RAM latency.

After each data access the pointer moves on to the next word, so a burst of consecutive words needs only one pointer setup. A mode register holds two independent bits that freeze the pointer after data reads, after data writes, or after both. That allows repeated polling or overwriting of a single location.

The pointer step that follows a data read is applied in the cycle after the read completes. A host access that lands in that cycle waits one cycle, except a pointer load, which completes at once and replaces the pending step.

Top module: `imw_port`

## Requirements
- R1: Register offsets on `h_addr` are 0x0 for the word pointer, 0x4 for the data window and 0x8 for the mode register. After reset the pointer and mode register read as 0. A pointer write keeps only the low log2(DEPTH) bits of `h_wdata`.
- R2: A write to offset 0x4 drives one RAM write cycle with `ram_en`=1 and `ram_we`=1. In that cycle `ram_addr` equals the current pointer and `ram_wdata` equals `h_wdata`.
- R3: A read of offset 0x4 returns the RAM word at the current pointer. `h_ready` stays low for RD_LAT+1 cycles from the first cycle of the request, and the data is valid in the cycle in which `h_ready` is high.
- R4: With mode bit 0 clear, the pointer advances by one word after each completed data-window read. The step lands in the cycle after completion.
- R5: With mode bit 1 clear, the pointer advances by one word at the clock edge that completes a data-window write.
- R6: With mode bit 0 set, data-window reads leave the pointer unchanged.
- R7: With mode bit 1 set, data-window writes leave the pointer unchanged. Bits 0 and 1 act independently of each other.
- R8: A step from location DEPTH-1 wraps the pointer to 0.
- R9: A pointer write in the cycle in which a read step is pending completes at once. The pointer takes the written value and the pending step is discarded.
- R10: Only bits 1:0 of the mode register are stored, and its other bits read as 0. Offsets other than 0x0, 0x4 and 0x8 read as 0, and writes to them change nothing.
- R11: Any access other than a pointer write that arrives while a read step is pending waits exactly one extra cycle with `h_ready` low. In all other cases, pointer, mode and undefined-offset accesses and data writes complete in the cycle they are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | HAW | Host register byte offset |
| h_wr | input | 1 | Host write request, held until `h_ready` |
| h_rd | input | 1 | Host read request, held until `h_ready` |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, valid while `h_ready` is high |
| h_ready | output | 1 | Access completes at the clock edge where this is high |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | log2(DEPTH) | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, valid RD_LAT cycles after the request edge |

## Verification
The bench builds the block with DEPTH=16, RD_LAT=2 and DW=32. The small depth brings the wrap from location 15 to 0 within a few accesses. It also lets a pointer write with bits set above the fourth show the truncation. A latency of 2 selects the counted wait variant of the read sequencer rather than the single-cycle one, which makes the RD_LAT+1 ready delay visible as three low cycles. Back-to-back accesses issued straight after data reads land in the pending-step cycle, and that is where the one-cycle stall and the pointer-load priority are exercised.

// File: rtl/imw_pkg.sv
package imw_pkg;

   typedef enum logic [1:0] {
      RS_IDLE,
      RS_WAIT,
      RS_HOLD
   } rd_state_e;

   localparam int unsigned OFS_PTR  = 0;
   localparam int unsigned OFS_DATA = 4;
   localparam int unsigned OFS_MODE = 8;

   localparam int unsigned MODE_KEEP_RD = 0;
   localparam int unsigned MODE_KEEP_WR = 1;
   localparam int unsigned MODE_W       = 2;

endpackage

// File: rtl/imw_addr_ctr.sv
module imw_addr_ctr #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_val;
      end else if (step) begin
         if (addr_q == LAST) addr_q <= '0;
         else                addr_q <= addr_q + AW'(1);
      end
   end

   assign addr_o = addr_q;

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr_q == $past(load_val));

   // R8
   step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && addr_q == LAST) |=> addr_q == '0);

   // R6
   hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(addr_q));

endmodule

// File: rtl/imw_rd_seq.sv
module imw_rd_seq
   import imw_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned RD_LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          allow,
   input  logic [DW-1:0] ram_rdata,
   output logic          issue_o,
   output logic          done_o,
   output logic          fire_o,
   output logic [DW-1:0] data_o
);

   localparam int unsigned CW = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);

   rd_state_e     state_q;
   logic [DW-1:0] data_q;
   logic          last_wait;

   generate
      if (RD_LAT == 1) begin : g_lat_one
         assign last_wait = 1'b1;
      end else begin : g_lat_cnt
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= CW'(1);
            else if (state_q != RS_WAIT) cnt_q <= CW'(1);
            else                         cnt_q <= cnt_q + CW'(1);
         end
         assign last_wait = (cnt_q == CW'(RD_LAT));
      end
   endgenerate

   assign issue_o = (state_q == RS_IDLE) && req && allow;
   assign done_o  = (state_q == RS_HOLD);
   assign fire_o  = done_o && req;
   assign data_o  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         data_q  <= '0;
      end else begin
         case (state_q)
            RS_IDLE: if (issue_o) state_q <= RS_WAIT;
            RS_WAIT: if (last_wait) begin
               data_q  <= ram_rdata;
               state_q <= RS_HOLD;
            end
            RS_HOLD: if (req) state_q <= RS_IDLE;
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   // R3
   no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |=> !done_o);

   // R3
   done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !req) |=> (done_o && $stable(data_o)));

endmodule

// File: rtl/imw_port.sv
module imw_port
   import imw_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned HAW    = 4,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [HAW-1:0] h_addr,
   input  logic           h_wr,
   input  logic           h_rd,
   input  logic [DW-1:0]  h_wdata,
   output logic [DW-1:0]  h_rdata,
   output logic           h_ready,
   output logic           ram_en,
   output logic           ram_we,
   output logic [AW-1:0]  ram_addr,
   output logic [DW-1:0]  ram_wdata,
   input  logic [DW-1:0]  ram_rdata
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("imw_port: DEPTH must be at least 2");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("imw_port: RD_LAT must be at least 1");
      end
      if (DW < AW || DW < MODE_W) begin : g_bad_dw
         $error("imw_port: DW too narrow for pointer readback");
      end
      if (HAW < 4) begin : g_bad_haw
         $error("imw_port: HAW must cover offset 0x8");
      end
   endgenerate

   logic              sel_ptr, sel_dat, sel_mode;
   logic              wr_ptr, wr_dat, wr_mode;
   logic              rd_req, rd_allow, rd_issue, rd_done, rd_fire;
   logic [DW-1:0]     rd_data;
   logic [MODE_W-1:0] mode_q;
   logic              pend_q;
   logic              step;
   logic [AW-1:0]     addr;

   assign sel_ptr  = (h_addr == HAW'(OFS_PTR));
   assign sel_dat  = (h_addr == HAW'(OFS_DATA));
   assign sel_mode = (h_addr == HAW'(OFS_MODE));

   assign wr_ptr   = h_wr && sel_ptr;
   assign wr_dat   = h_wr && sel_dat && !pend_q;
   assign wr_mode  = h_wr && sel_mode && !pend_q;
   assign rd_req   = h_rd && sel_dat;
   assign rd_allow = !pend_q && !h_wr;

   assign step = pend_q || (wr_dat && !mode_q[MODE_KEEP_WR]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= h_wdata[MODE_W-1:0];
         pend_q <= rd_fire && !mode_q[MODE_KEEP_RD];
      end
   end

   imw_addr_ctr #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ptr),
      .load_val (h_wdata[AW-1:0]),
      .step     (step),
      .addr_o   (addr)
   );

   imw_rd_seq #(
      .DW     (DW),
      .RD_LAT (RD_LAT)
   ) u_rdseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (rd_req),
      .allow     (rd_allow),
      .ram_rdata (ram_rdata),
      .issue_o   (rd_issue),
      .done_o    (rd_done),
      .fire_o    (rd_fire),
      .data_o    (rd_data)
   );

   assign ram_en    = wr_dat || rd_issue;
   assign ram_we    = wr_dat;
   assign ram_addr  = addr;
   assign ram_wdata = h_wdata;

   always_comb begin
      if (wr_ptr)      h_ready = 1'b1;
      else if (pend_q) h_ready = 1'b0;
      else if (rd_req) h_ready = rd_done;
      else             h_ready = 1'b1;
   end

   always_comb begin
      h_rdata = '0;
      if (sel_dat)       h_rdata = rd_data;
      else if (sel_ptr)  h_rdata = DW'(addr);
      else if (sel_mode) h_rdata = DW'(mode_q);
   end

   // R11
   pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !pend_q);

   // R4
   read_step_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !mode_q[MODE_KEEP_RD]) |=> (!h_ready || wr_ptr));

endmodule

// File: tb/imw_port_tb_top.sv
`timescale 1ns/1ps
module imw_port_tb_top;

   localparam int unsigned DW     = 32;
   localparam int unsigned DEPTH  = 16;
   localparam int unsigned RD_LAT = 2;
   localparam int unsigned HAW    = 4;
   localparam int unsigned AW     = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [HAW-1:0] h_addr = '0;
   logic           h_wr = 1'b0;
   logic           h_rd = 1'b0;
   logic [DW-1:0]  h_wdata = '0;
   logic [DW-1:0]  h_rdata;
   logic           h_ready;
   logic           ram_en, ram_we;
   logic [AW-1:0]  ram_addr;
   logic [DW-1:0]  ram_wdata;
   logic [DW-1:0]  ram_rdata;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   imw_port #(.DW(DW), .DEPTH(DEPTH), .RD_LAT(RD_LAT), .HAW(HAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // environment RAM: two-cycle read latency
   logic [DW-1:0] ram_arr [DEPTH];
   logic [DW-1:0] pipe1, pipe2;
   initial for (int i = 0; i < DEPTH; i++) ram_arr[i] = '0;
   always @(posedge clk) begin
      if (ram_en && ram_we) ram_arr[ram_addr] <= ram_wdata;
      if (ram_en && !ram_we) pipe1 <= ram_arr[ram_addr];
      pipe2 <= pipe1;
   end
   assign ram_rdata = pipe2;

   // behavioural reference
   int unsigned   m_addr = 0;
   int unsigned   m_mode = 0;
   bit            m_pend = 0;
   logic [DW-1:0] m_mem [DEPTH];
   logic [DW-1:0] m_wd = '0;
   initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // per-clock comparison of RAM traffic against the reference
   always @(negedge clk) begin
      #1.5;
      if (rst_n && ram_en) begin
         chk("R2", "ram_addr", ram_addr, m_addr);
         if (ram_we) chk("R2", "ram_wdata", ram_wdata, m_wd);
      end
   end

   function automatic void settle(input bit is_ptr_wr);
      if (m_pend && !is_ptr_wr) m_addr = (m_addr + 1) % DEPTH;
   endfunction

   task automatic reg_wr(input int unsigned off, input logic [DW-1:0] val, input string tag);
      int w = 0;
      int exp_w;
      exp_w = (m_pend && off != 0) ? 1 : 0;
      h_addr = HAW'(off); h_wdata = val; h_wr = 1'b1; #1;
      while (!h_ready && w < 40) begin
         @(negedge clk); #1; w++;
         if (w == 1) begin settle(off == 0); m_pend = 0; end
      end
      if (w == 0) begin settle(off == 0); m_pend = 0; end
      m_wd = val;
      @(posedge clk);
      if (off == 0) m_addr = val[AW-1:0];
      else if (off == 4) begin
         m_mem[m_addr] = val;
         if (!m_mode[1]) m_addr = (m_addr + 1) % DEPTH;
      end else if (off == 8) m_mode = val[1:0];
      @(negedge clk);
      h_wr = 1'b0;
      chk(tag, "write wait cycles", w, exp_w);
   endtask

   task automatic reg_rd(input int unsigned off, input string tag);
      int w = 0;
      int exp_w;
      logic [DW-1:0] d;
      logic [DW-1:0] exp_d;
      exp_w = (m_pend ? 1 : 0) + ((off == 4) ? RD_LAT + 1 : 0);
      settle(1'b0); m_pend = 0;
      if (off == 0)      exp_d = DW'(m_addr);
      else if (off == 4) exp_d = m_mem[m_addr];
      else if (off == 8) exp_d = DW'(m_mode);
      else               exp_d = '0;
      h_addr = HAW'(off); h_rd = 1'b1; #1;
      while (!h_ready && w < 40) begin @(negedge clk); #1; w++; end
      d = h_rdata;
      @(posedge clk);
      if (off == 4 && !m_mode[0]) m_pend = 1;
      @(negedge clk);
      h_rd = 1'b0;
      chk(tag, "read data", d, exp_d);
      chk(tag, "read wait cycles", w, exp_w);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      reg_rd(0, "R1");
      reg_rd(8, "R1");
      // R1 truncation of pointer write, R11 immediate completion
      reg_wr(0, 32'h23, "R1");
      reg_rd(0, "R11");
      // R5 burst writes from 3
      reg_wr(0, 3, "R1");
      reg_wr(4, 32'hA0A0_0001, "R5");
      reg_wr(4, 32'hB0B0_0002, "R5");
      reg_wr(4, 32'hC0C0_0003, "R5");
      reg_rd(0, "R5");
      // R3 R4 burst reads, each following access lands in the pending cycle
      reg_wr(0, 3, "R1");
      reg_rd(4, "R3");
      reg_rd(4, "R4");
      reg_rd(4, "R4");
      reg_rd(0, "R4");
      // R6 freeze on read, writes still step (R7 independence)
      reg_wr(8, 32'h1, "R6");
      reg_wr(0, 3, "R6");
      reg_rd(4, "R6");
      reg_rd(4, "R6");
      reg_rd(0, "R6");
      reg_wr(4, 32'hD0D0_0004, "R7");
      reg_rd(0, "R7");
      // R7 freeze on write, reads still step
      reg_wr(8, 32'h2, "R7");
      reg_wr(0, 10, "R7");
      reg_wr(4, 32'h1111_1111, "R7");
      reg_wr(4, 32'hE0E0_0005, "R7");
      reg_rd(0, "R7");
      reg_rd(4, "R7");
      reg_rd(0, "R7");
      // R10 unused mode bits
      reg_wr(8, 32'hFFFF_FFFC, "R10");
      reg_rd(8, "R10");
      reg_wr(8, 32'hF, "R10");
      reg_rd(8, "R10");
      reg_wr(8, 32'h0, "R10");
      // R8 wrap on write and read
      reg_wr(0, 15, "R8");
      reg_wr(4, 32'hF0F0_000F, "R8");
      reg_rd(0, "R8");
      reg_wr(0, 15, "R8");
      reg_rd(4, "R8");
      reg_rd(0, "R8");
      // R9 pointer load in the pending cycle
      reg_wr(0, 5, "R9");
      reg_rd(4, "R9");
      reg_wr(0, 9, "R9");
      reg_rd(0, "R9");
      // R11 data write in pending cycle waits one
      reg_wr(0, 6, "R11");
      reg_rd(4, "R11");
      reg_wr(4, 32'h7777_0007, "R11");
      reg_rd(0, "R11");
      // R10 undefined offset
      reg_wr(12, 32'hDEAD_BEEF, "R10");
      reg_rd(12, "R10");
      reg_rd(0, "R10");
      reg_rd(8, "R10");
      reg_wr(0, 6, "R10");
      reg_rd(4, "R10");
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule